// File: doc/BRIEF.md
# Invalidation Acknowledgment Collector

This block sits beside one directory entry and tracks the acknowledgments that come back after a write has forced invalidations of cached copies. Software loads it with the number of invalidations it sent, a collection mode and the writer's node number. From then on, every incoming acknowledgment decrements a single count register. This register is the same storage that otherwise holds a sharer pointer. While the count is nonzero, the block answers any other request for the entry with a busy reply. This keeps competing requesters from starving the writer.

The mode picks how much software sees. In every-ack mode, each acknowledgment raises a trap. In last-ack mode, the hardware absorbs all acknowledgments but the final one, which traps so that software can send the data to the writer. In full-hardware mode, a second field keeps the writer's node number, and the final acknowledgment raises a completion pulse carrying that number without any trap. An acknowledgment that arrives with nothing outstanding is reported as a protocol error. A load that arrives during a collection is refused, as is a load that is malformed. All event outputs are registered pulses that appear one clock after the input that caused them.

Top module: `ackc_collector`

## Requirements
- R1: After reset, `pending` is 0 and every pulse output (`busy`, `trap`, `trap_last`, `wr_done`, `ack_err`, `load_rej`) is 0, with `wr_node` 0.
- R2: A load with `load_valid`=1, a nonzero `load_count` and a `load_mode` other than 3, presented while `pending` is 0, is accepted: `pending` is 1 after that clock edge.
- R3: Each acknowledgment taken while the count is nonzero decrements it by one. `pending` falls after the edge that takes the final acknowledgment, so exactly N acknowledgments drain a load of N.
- R4: `req_valid` while `pending` is 1 yields `busy`=1 in the next cycle. `req_valid` while `pending` is 0 yields `busy`=0.
- R5: In every-ack mode (`load_mode`=0), every taken acknowledgment raises `trap` one cycle later. `trap_last` is 1 only with the trap for the final one.
- R6: In last-ack mode (`load_mode`=1), only the final acknowledgment raises `trap`, together with `trap_last`=1. All earlier acknowledgments raise nothing.
- R7: In full-hardware mode (`load_mode`=2), no acknowledgment raises `trap`. The final one raises `wr_done` with `wr_node` equal to the writer number given at load. `wr_node` is 0 whenever `wr_done` is 0.
- R8: An acknowledgment arriving while `pending` is 0 raises `ack_err` and leaves `pending` at 0; the count does not wrap.
- R9: A load presented while `pending` is 1 raises `load_rej` and does not change the outstanding count, mode or writer.
- R10: A load with `load_count`=0 or `load_mode`=3 raises `load_rej` and leaves the block idle.
- R11: In last-ack mode with 64 outstanding acknowledgments, the first 63 raise no trap and the 64th raises exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Software loads a new collection |
| load_count | input | CNT_W | Number of invalidations sent |
| load_mode | input | 2 | 0 every-ack, 1 last-ack, 2 full-hardware, 3 reserved |
| load_writer | input | NODE_W | Node number of the writer |
| ack_valid | input | 1 | An acknowledgment message arrived |
| req_valid | input | 1 | Another request for this entry arrived |
| pending | output | 1 | Acknowledgments are outstanding |
| busy | output | 1 | Send a busy reply to the request of the previous cycle |
| trap | output | 1 | Software trap request |
| trap_last | output | 1 | The trap is for the final acknowledgment |
| wr_done | output | 1 | Full-hardware collection completed |
| wr_node | output | NODE_W | Writer to receive data, valid with `wr_done` |
| ack_err | output | 1 | Acknowledgment arrived with nothing outstanding |
| load_rej | output | 1 | Load refused |

## Verification
The bench goes after the boundaries of the count. If the final acknowledgment were decoded one step early, the trap or completion pulse would come early, or `pending` would fall with one acknowledgment still unaccounted for. A stray acknowledgment on an idle entry would wrap the counter in a design without the zero guard, leaving `pending` stuck high and every later request answered busy. A load during a collection, or a load with a zero count or reserved mode, is checked by draining afterwards: an overwrite shows up as the wrong number of acknowledgments before `pending` falls. A long last-ack collection and a randomized run, both compared cycle by cycle with a behavioural model, expose any trap leaking from a middle acknowledgment, or any trap raised in full-hardware mode.

// File: rtl/ackc_pkg.sv
package ackc_pkg;
    typedef enum logic [1:0] {
        MODE_EVERY = 2'd0,
        MODE_LAST  = 2'd1,
        MODE_HW    = 2'd2,
        MODE_RSVD  = 2'd3
    } ack_mode_e;
endpackage

// File: rtl/ackc_counter.sv
module ackc_counter
    import ackc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [CNT_W-1:0]  load_count,
    input  ack_mode_e         load_mode,
    input  logic [NODE_W-1:0] load_writer,
    input  logic              ack_valid,
    output logic              active,
    output logic              ack_taken,
    output logic              ack_final,
    output logic              ack_stray,
    output logic              load_refused,
    output ack_mode_e         mode,
    output logic [NODE_W-1:0] node
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;   // shared pointer field, used as ack count
        ack_mode_e         mode;
        logic [NODE_W-1:0] node;  // second field: writer id
    } st_t;

    st_t  st_d, st_q;
    logic load_ok;

    always_comb begin
        active       = (st_q.cnt != '0);
        load_ok      = load_valid && !active && (load_count != '0) && (load_mode != MODE_RSVD);
        load_refused = load_valid && !load_ok;
        ack_taken    = ack_valid && active;
        ack_final    = ack_taken && (st_q.cnt == ONE);
        ack_stray    = ack_valid && !active;
        st_d         = st_q;
        if (ack_taken) st_d.cnt = st_q.cnt - ONE;
        if (load_ok) begin
            st_d.cnt  = load_count;
            st_d.mode = load_mode;
            st_d.node = load_writer;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, mode: MODE_EVERY, node: '0};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign node = st_q.node;

    // R3: a taken acknowledgment lowers the count by exactly one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        ack_taken |=> st_q.cnt == $past(st_q.cnt) - ONE);
    // R8: a stray acknowledgment never wraps the counter
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stray && !load_valid) |=> !active);
    // R9: a load during collection leaves mode and writer untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && active) |=> ($stable(st_q.mode) && $stable(st_q.node)));
endmodule

// File: rtl/ackc_signal.sv
module ackc_signal
    import ackc_pkg::*;
#(
    parameter int NODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              active,
    input  logic              ack_taken,
    input  logic              ack_final,
    input  logic              ack_stray,
    input  logic              load_refused,
    input  ack_mode_e         mode,
    input  logic [NODE_W-1:0] node,
    output logic              busy,
    output logic              trap,
    output logic              trap_last,
    output logic              wr_done,
    output logic [NODE_W-1:0] wr_node,
    output logic              ack_err,
    output logic              load_rej
);
    typedef struct packed {
        logic              busy;
        logic              trap;
        logic              last;
        logic              done;
        logic [NODE_W-1:0] node;
        logic              err;
        logic              rej;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d      = '0;
        ev_d.busy = req_valid && active;
        unique case (mode)
            MODE_EVERY: ev_d.trap = ack_taken;
            MODE_LAST:  ev_d.trap = ack_final;
            default:    ev_d.trap = 1'b0;
        endcase
        ev_d.last = ev_d.trap && ack_final;
        ev_d.done = ack_final && (mode == MODE_HW);
        ev_d.node = ev_d.done ? node : '0;
        ev_d.err  = ack_stray;
        ev_d.rej  = load_refused;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign busy      = ev_q.busy;
    assign trap      = ev_q.trap;
    assign trap_last = ev_q.last;
    assign wr_done   = ev_q.done;
    assign wr_node   = ev_q.node;
    assign ack_err   = ev_q.err;
    assign load_rej  = ev_q.rej;

    // R4: an outstanding collection always answers busy
    a_r4_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && active) |=> busy);
    // R7: full-hardware mode never traps
    a_r7_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_taken && mode == MODE_HW) |=> !trap);
    // R5: final flag only accompanies a trap, never a completion pulse
    a_r5_last_with_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_last |-> (trap && !wr_done));
endmodule

// File: rtl/ackc_collector.sv
module ackc_collector
    import ackc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [CNT_W-1:0]  load_count,
    input  logic [1:0]        load_mode,
    input  logic [NODE_W-1:0] load_writer,
    input  logic              ack_valid,
    input  logic              req_valid,
    output logic              pending,
    output logic              busy,
    output logic              trap,
    output logic              trap_last,
    output logic              wr_done,
    output logic [NODE_W-1:0] wr_node,
    output logic              ack_err,
    output logic              load_rej
);
    logic              active, ack_taken, ack_final, ack_stray, load_refused;
    ack_mode_e         mode;
    logic [NODE_W-1:0] node;

    ackc_counter #(.CNT_W(CNT_W), .NODE_W(NODE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_count(load_count),
        .load_mode(ack_mode_e'(load_mode)), .load_writer(load_writer),
        .ack_valid(ack_valid),
        .active(active), .ack_taken(ack_taken), .ack_final(ack_final),
        .ack_stray(ack_stray), .load_refused(load_refused),
        .mode(mode), .node(node)
    );

    ackc_signal #(.NODE_W(NODE_W)) u_sig (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .active(active), .ack_taken(ack_taken), .ack_final(ack_final),
        .ack_stray(ack_stray), .load_refused(load_refused),
        .mode(mode), .node(node),
        .busy(busy), .trap(trap), .trap_last(trap_last),
        .wr_done(wr_done), .wr_node(wr_node),
        .ack_err(ack_err), .load_rej(load_rej)
    );

    assign pending = active;

    // R2: a well-formed load on an idle entry starts a collection
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !pending && load_count != '0 && load_mode != 2'd3) |=> pending);
endmodule

// File: tb/ackc_collector_test.sv
`timescale 1ns/1ps
module ackc_collector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_valid = 1'b0;
    logic [7:0] load_count = '0;
    logic [1:0] load_mode = '0;
    logic [5:0] load_writer = '0;
    logic       ack_valid = 1'b0;
    logic       req_valid = 1'b0;
    logic       pending, busy, trap, trap_last, wr_done, ack_err, load_rej;
    logic [5:0] wr_node;

    int tests = 0;
    int fails = 0;
    int m_cnt = 0, m_mode = 0, m_node = 0;
    int trap_seen;

    always #2 clk = ~clk;

    ackc_collector #(.CNT_W(8), .NODE_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_count(load_count),
        .load_mode(load_mode), .load_writer(load_writer), .ack_valid(ack_valid),
        .req_valid(req_valid), .pending(pending), .busy(busy), .trap(trap),
        .trap_last(trap_last), .wr_done(wr_done), .wr_node(wr_node),
        .ack_err(ack_err), .load_rej(load_rej)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit lv, input int lc, input int lm, input int lw,
                       input bit av, input bit rv);
        bit act, taken, fin, lok;
        int e_busy, e_trap, e_last, e_done, e_node, e_err, e_rej;
        string treq;
        load_valid = lv; load_count = lc[7:0]; load_mode = lm[1:0];
        load_writer = lw[5:0]; ack_valid = av; req_valid = rv;
        act    = (m_cnt != 0);
        taken  = av && act;
        fin    = taken && (m_cnt == 1);
        e_busy = rv && act;
        e_trap = taken && (m_mode == 0 || (m_mode == 1 && fin));
        e_last = e_trap && fin;
        e_done = fin && (m_mode == 2);
        e_node = e_done ? m_node : 0;
        e_err  = av && !act;
        lok    = lv && !act && (lc[7:0] != 0) && (lm != 3);
        e_rej  = lv && !lok;
        treq   = (m_mode == 0) ? "R5" : (m_mode == 1) ? "R6" : "R7";
        if (taken) m_cnt--;
        if (lok) begin m_cnt = lc[7:0]; m_mode = lm; m_node = lw[5:0]; end
        @(posedge clk); #1;
        check("R2/R3", "pending", pending, (m_cnt != 0));
        check("R4", "busy", busy, e_busy);
        check(treq, "trap", trap, e_trap);
        check(treq, "trap_last", trap_last, e_last);
        check("R7", "wr_done", wr_done, e_done);
        check("R7", "wr_node", wr_node, e_node);
        check("R8", "ack_err", ack_err, e_err);
        check("R9/R10", "load_rej", load_rej, e_rej);
        if (trap) trap_seen++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "pending", pending, 0);
        check("R1", "pulses", {busy, trap, trap_last, wr_done, ack_err, load_rej}, 0);
        check("R1", "wr_node", wr_node, 0);
        rst_n = 1'b1;
        cyc(0,0,0,0,0,0);
        // R4 idle request gets no busy
        cyc(0,0,0,0,0,1);
        // R6 last-ack mode, 3 acks, with busy replies in between
        cyc(1,3,1,5,0,0);
        cyc(0,0,0,0,1,1);
        cyc(0,0,0,0,0,1);
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,1,1);
        cyc(0,0,0,0,0,1);
        // R5 every-ack mode
        cyc(1,2,0,7,0,0);
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,1,0);
        // R7 full-hardware mode
        cyc(1,2,2,9,0,0);
        cyc(0,0,0,0,1,1);
        cyc(0,0,0,0,1,0);
        // R8 stray ack on idle entry, then idle again
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,0,1);
        // R9 load during collection refused, count preserved
        cyc(1,2,1,3,0,0);
        cyc(1,5,2,11,0,0);
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,0,1);
        // R10 zero count and reserved mode refused
        cyc(1,0,1,4,0,0);
        cyc(1,4,3,4,0,0);
        cyc(0,0,0,0,1,0);
        // R11 64 acknowledgments in last-ack mode: one trap, on the last
        cyc(1,64,1,2,0,0);
        trap_seen = 0;
        for (int i = 0; i < 63; i++) cyc(0,0,0,0,1,(i % 5) == 0);
        check("R11", "traps before final ack", trap_seen, 0);
        cyc(0,0,0,0,1,0);
        check("R11", "traps after final ack", trap_seen, 1);
        // randomized traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 12, $urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 63),
                $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 30);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule